// File: doc/BRIEF.md
# Halfword and Signed-Byte Load/Store Address Decoder

This block decodes one instruction word of the miscellaneous load/store class. That class covers halfword loads and stores, signed byte and signed halfword loads, and two-register (doubleword) transfers. From the word it finds the access kind, the offset source and the indexing mode. The offset is either an 8-bit constant split over two nibbles or an index register value. The mode is plain offset, pre-indexed or post-indexed. The block then forms the memory address and the value to write back to the base register.

The execute stage feeds it the instruction word, the base and index register values, the address of the current instruction, and a flag that says whether the instruction's condition passed. One clock later the block returns these registered outputs:
- the access address;
- the writeback value and its enable;
- an access-kind code;
- three flags, for words outside the class, for unallocated encodings and for operand choices with undefined results.

It performs no memory access, does no extension of loaded data and makes no register file write.

Top module: `hsd_agen`

## Requirements
- R1: A word is a member of the class only when bits 27:25 are 000, bit 7 is 1, bit 4 is 1, and bits 6 (S) and 5 (H) are not both 0. For any other word `not_member` is 1, `acc_kind` is 0 and `wb_en` is 0.
- R2: Bit 22 set selects the constant offset. Its value is bits 11:8 as the upper nibble and bits 3:0 as the lower nibble, zero-extended. Bit 22 clear selects `idx_val` as the offset.
- R3: Bit 23 set adds the offset to the base. Bit 23 clear subtracts it. Both wrap modulo 2^32.
- R4: With bit 24 set, the address is base plus or minus the offset, and writeback is requested only when bit 21 is set. With bit 24 clear, the address is the unmodified base and writeback is always requested.
- R5: `wb_data` is base plus or minus the offset in every mode. `wb_en` is 1 only for a requested writeback of a member, non-unallocated word while `cond_ok` is 1.
- R6: When the base field (bits 19:16) is 15, the base used is `pc_val + 8`.
- R7: `acc_kind` takes its value from S, H and L (bit 20):
  - 1: S=0, H=1, L=0 (halfword store)
  - 2: S=0, H=1, L=1 (halfword load)
  - 3: S=1, H=0, L=1 (signed byte load)
  - 4: S=1, H=1, L=1 (signed halfword load)

  With the default `DWORD_EN=0`, a member word with S=1 and L=0 sets `unalloc` and gives kind 0 and no writeback. With `DWORD_EN=1` it gives 5 for H=0 (doubleword load) and 6 for H=1 (doubleword store).
- R8: For a member word, `unpred` is 1 when any of the following holds. A writeback form is bit 24 clear or bit 21 set.
  - In the register form, bits 3:0 are 15.
  - In the register form, bits 11:8 are not zero.
  - In a writeback form, the base field is 15.
  - In a register form that is also a writeback form, the base field equals bits 3:0.
- R9: All outputs are registered with one cycle of latency. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn | input | 32 | Instruction word |
| base_val | input | 32 | Base register value |
| idx_val | input | 32 | Index register value |
| pc_val | input | 32 | Address of the current instruction |
| cond_ok | input | 1 | Condition of the instruction passed |
| acc_addr | output | 32 | Memory access address |
| wb_data | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register writeback enable |
| acc_kind | output | 3 | Access-kind code (R7) |
| not_member | output | 1 | Word is outside the class |
| unalloc | output | 1 | Unallocated encoding |
| unpred | output | 1 | Operand choice with undefined result |

## Verification
A wrong decode of the mode bits shows up one cycle later in `acc_addr`: a post-indexed access carries the moved pointer instead of the raw base, or a plain offset access raises `wb_en`. A fault in the offset nibble order or in the add/subtract choice changes both `acc_addr` and `wb_data` in the same cycle. The sweep over every mode, sign, kind and load/store combination exposes this within a few vectors. Flag faults are caught directly at the ports on the very next edge, because the member, unallocated and undefined-operand words are driven with distinct, known register fields.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int DW = 32;
  localparam int RW = 4;

  typedef enum logic [2:0] {
    K_NONE     = 3'd0,
    K_HALF_ST  = 3'd1,
    K_HALF_LD  = 3'd2,
    K_SBYTE_LD = 3'd3,
    K_SHALF_LD = 3'd4,
    K_DWORD_LD = 3'd5,
    K_DWORD_ST = 3'd6
  } acc_kind_e;

  typedef struct packed {
    logic          pre;
    logic          up;
    logic          imm_form;
    logic          wback;
    logic          load;
    logic          sgn;
    logic          half;
    logic [RW-1:0] base_sel;
    logic [RW-1:0] hi_nib;
    logic [RW-1:0] lo_nib;
  } fields_t;

  function automatic logic [DW-1:0] join_nibbles(input logic [RW-1:0] hi,
                                                 input logic [RW-1:0] lo);
    logic [DW-1:0] r;
    r = '0;
    r[2*RW-1:0] = {hi, lo};
    return r;
  endfunction

  function automatic logic [DW-1:0] step(input logic [DW-1:0] a,
                                         input logic [DW-1:0] b,
                                         input logic add);
    return add ? (a + b) : (a - b);
  endfunction
endpackage

// File: rtl/hsd_decode.sv
module hsd_decode
  import hsd_pkg::*;
#(
  parameter bit DWORD_EN = 1'b0
) (
  input  logic [31:0] insn,
  output fields_t     fld,
  output logic        member,
  output logic        wb_form,
  output logic        unalloc_c,
  output logic        unpred_c,
  output acc_kind_e   kind_c
);
  localparam logic [RW-1:0] PCREG = {RW{1'b1}};

  logic pair_kind;
  logic idx_is_pc, base_is_pc, same_reg, sbz_bad;

  always_comb begin
    fld.pre      = insn[24];
    fld.up       = insn[23];
    fld.imm_form = insn[22];
    fld.wback    = insn[21];
    fld.load     = insn[20];
    fld.base_sel = insn[19:16];
    fld.hi_nib   = insn[11:8];
    fld.sgn      = insn[6];
    fld.half     = insn[5];
    fld.lo_nib   = insn[3:0];
  end

  assign member  = (insn[27:25] == 3'b000) && insn[7] && insn[4] &&
                   (fld.sgn || fld.half);
  assign wb_form = !fld.pre || fld.wback;
  assign pair_kind = fld.sgn && !fld.load;

  // the parameter picks what a signed store pattern means
  generate
    if (DWORD_EN) begin : g_pair
      assign unalloc_c = 1'b0;
    end else begin : g_nopair
      assign unalloc_c = member && pair_kind;
    end
  endgenerate

  always_comb begin
    kind_c = K_NONE;
    if (member) begin
      unique case ({fld.sgn, fld.half, fld.load})
        3'b010:  kind_c = K_HALF_ST;
        3'b011:  kind_c = K_HALF_LD;
        3'b101:  kind_c = K_SBYTE_LD;
        3'b111:  kind_c = K_SHALF_LD;
        3'b100:  kind_c = DWORD_EN ? K_DWORD_LD : K_NONE;
        3'b110:  kind_c = DWORD_EN ? K_DWORD_ST : K_NONE;
        default: kind_c = K_NONE;
      endcase
    end
  end

  assign idx_is_pc  = !fld.imm_form && (fld.lo_nib == PCREG);
  assign base_is_pc = wb_form && (fld.base_sel == PCREG);
  assign same_reg   = !fld.imm_form && wb_form && (fld.base_sel == fld.lo_nib);
  assign sbz_bad    = !fld.imm_form && (fld.hi_nib != '0);
  assign unpred_c   = member && (idx_is_pc || base_is_pc || same_reg || sbz_bad);
endmodule

// File: rtl/hsd_agu.sv
module hsd_agu
  import hsd_pkg::*;
#(
  parameter int PC_AHEAD = 8
) (
  input  fields_t       fld,
  input  logic [DW-1:0] base_val,
  input  logic [DW-1:0] idx_val,
  input  logic [DW-1:0] pc_val,
  output logic [DW-1:0] eff_base,
  output logic [DW-1:0] offset,
  output logic [DW-1:0] addr_c,
  output logic [DW-1:0] moved_c
);
  localparam logic [DW-1:0] AHEAD = DW'(PC_AHEAD);
  localparam logic [RW-1:0] PCREG = {RW{1'b1}};

  assign eff_base = (fld.base_sel == PCREG) ? (pc_val + AHEAD) : base_val;
  assign offset   = fld.imm_form ? join_nibbles(fld.hi_nib, fld.lo_nib) : idx_val;
  assign moved_c  = step(eff_base, offset, fld.up);
  assign addr_c   = fld.pre ? moved_c : eff_base;
endmodule

// File: rtl/hsd_agen.sv
module hsd_agen
  import hsd_pkg::*;
#(
  parameter bit DWORD_EN = 1'b0,
  parameter int PC_AHEAD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] insn,
  input  logic [31:0] base_val,
  input  logic [31:0] idx_val,
  input  logic [31:0] pc_val,
  input  logic        cond_ok,
  output logic [31:0] acc_addr,
  output logic [31:0] wb_data,
  output logic        wb_en,
  output logic [2:0]  acc_kind,
  output logic        not_member,
  output logic        unalloc,
  output logic        unpred
);
  fields_t       fld;
  logic          dec_member, dec_wbform, dec_unalloc, dec_unpred;
  acc_kind_e     dec_kind;
  logic [DW-1:0] eff_base, offset, addr_c, moved_c;
  logic          wb_go;

  hsd_decode #(.DWORD_EN(DWORD_EN)) u_dec (
    .insn      (insn),
    .fld       (fld),
    .member    (dec_member),
    .wb_form   (dec_wbform),
    .unalloc_c (dec_unalloc),
    .unpred_c  (dec_unpred),
    .kind_c    (dec_kind)
  );

  hsd_agu #(.PC_AHEAD(PC_AHEAD)) u_agu (
    .fld      (fld),
    .base_val (base_val),
    .idx_val  (idx_val),
    .pc_val   (pc_val),
    .eff_base (eff_base),
    .offset   (offset),
    .addr_c   (addr_c),
    .moved_c  (moved_c)
  );

  assign wb_go = dec_member && !dec_unalloc && dec_wbform && cond_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr   <= '0;
      wb_data    <= '0;
      wb_en      <= 1'b0;
      acc_kind   <= '0;
      not_member <= 1'b0;
      unalloc    <= 1'b0;
      unpred     <= 1'b0;
    end else begin
      acc_addr   <= addr_c;
      wb_data    <= moved_c;
      wb_en      <= wb_go;
      acc_kind   <= dec_kind;
      not_member <= !dec_member;
      unalloc    <= dec_unalloc;
      unpred     <= dec_unpred;
    end
  end

  // R5
  cond_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> !wb_en);
  // R1
  outsider_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_member |-> (acc_kind == 3'd0 && !wb_en));
  // R7
  unalloc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unalloc |-> (!wb_en && acc_kind == 3'd0 && !not_member));
  // R4
  post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_member && !fld.pre) |=> (acc_addr == $past(eff_base)));
  // R4
  plain_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fld.pre && !fld.wback) |=> !wb_en);
  // R5
  wb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_member && fld.pre) |=> (acc_addr == wb_data));
endmodule

// File: tb/hsd_agen_tb.sv
module hsd_agen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0, base_val = '0, idx_val = '0, pc_val = '0;
  logic        cond_ok = 1'b0;
  logic [31:0] acc_addr, wb_data;
  logic        wb_en, not_member, unalloc, unpred;
  logic [2:0]  acc_kind;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hsd_agen u_dut (
    .clk(clk), .rst_n(rst_n), .insn(insn), .base_val(base_val),
    .idx_val(idx_val), .pc_val(pc_val), .cond_ok(cond_ok),
    .acc_addr(acc_addr), .wb_data(wb_data), .wb_en(wb_en),
    .acc_kind(acc_kind), .not_member(not_member), .unalloc(unalloc),
    .unpred(unpred)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] w;
    logic        en;
    logic [2:0]  k;
    logic        nm;
    logic        ua;
    logic        up;
  } res_t;

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] base;
    logic [31:0] idx;
    logic [31:0] pc;
    logic        cond;
    logic [31:0] ea;
    logic [31:0] ew;
    logic        een;
    logic [2:0]  ek;
  } vec_t;

  function automatic logic [31:0] mk(input bit p, input bit u, input bit i,
      input bit w, input bit l, input logic [3:0] rn, input logic [3:0] hi,
      input bit s, input bit h, input logic [3:0] lo);
    return {4'hE, 3'b000, p, u, i, w, l, rn, 4'h0, hi, 1'b1, s, h, 1'b1, lo};
  endfunction

  localparam vec_t TBL [6] = '{
    '{mk(1,1,1,0,1,4'd2,4'hA,0,1,4'h5), 32'h1000, 32'h0, 32'h0, 1'b1,
      32'h10A5, 32'h10A5, 1'b0, 3'd2},
    '{mk(1,0,1,1,1,4'd3,4'h1,1,0,4'h0), 32'h2000, 32'h0, 32'h0, 1'b1,
      32'h1FF0, 32'h1FF0, 1'b1, 3'd3},
    '{mk(0,1,0,0,1,4'd4,4'h0,1,1,4'd5), 32'h3000, 32'h44, 32'h0, 1'b1,
      32'h3000, 32'h3044, 1'b1, 3'd4},
    '{mk(1,1,1,0,0,4'd15,4'h0,0,1,4'h4), 32'h7777, 32'h0, 32'h100, 1'b1,
      32'h10C, 32'h10C, 1'b0, 3'd1},
    '{mk(1,0,0,0,1,4'd8,4'h0,0,1,4'd9), 32'h0, 32'h1, 32'h0, 1'b1,
      32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'd2},
    '{mk(0,0,1,0,1,4'd1,4'h0,0,1,4'h8), 32'h50, 32'h0, 32'h0, 1'b0,
      32'h50, 32'h48, 1'b0, 3'd2}
  };

  // behavioural model, written from the requirements
  function automatic res_t model(input logic [31:0] iw, input logic [31:0] b,
      input logic [31:0] x, input logic [31:0] pc, input logic c);
    res_t r;
    logic mem, wbf, regf;
    logic [31:0] base, off, delta;
    mem  = (iw[27:25] == 3'b000) && iw[7] && iw[4] && (iw[6] || iw[5]);
    regf = !iw[22];
    wbf  = (iw[24] == 1'b0) || iw[21];
    base = (iw[19:16] == 4'd15) ? pc + 32'd8 : b;
    off  = regf ? x : {24'd0, iw[11:8], iw[3:0]};
    delta = iw[23] ? off : (~off + 32'd1);
    r.w  = base + delta;
    r.a  = iw[24] ? r.w : base;
    r.nm = !mem;
    r.ua = mem && iw[6] && !iw[20];
    r.k  = 3'd0;
    if (mem && !r.ua) begin
      if (!iw[6]) r.k = iw[20] ? 3'd2 : 3'd1;
      else        r.k = iw[5] ? 3'd4 : 3'd3;
    end
    r.en = mem && !r.ua && wbf && c;
    r.up = mem && ((regf && iw[3:0] == 4'd15) || (regf && iw[11:8] != 4'd0) ||
                   (wbf && iw[19:16] == 4'd15) ||
                   (regf && wbf && iw[19:16] == iw[3:0]));
    return r;
  endfunction

  function automatic res_t got();
    return '{acc_addr, wb_data, wb_en, acc_kind, not_member, unalloc, unpred};
  endfunction

  task automatic check(input string req, input res_t act, input res_t exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] iw, input logic [31:0] b,
      input logic [31:0] x, input logic [31:0] pc, input logic c);
    @(negedge clk);
    insn = iw; base_val = b; idx_val = x; pc_val = pc; cond_ok = c;
    @(posedge clk);
    #1;
  endtask

  task automatic run(input string req, input logic [31:0] iw,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] pc,
      input logic c);
    apply(iw, b, x, pc, c);
    check(req, got(), model(iw, b, x, pc, c));
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    res_t z;
    // R9 reset state with live inputs
    z = '0;
    insn = mk(1,1,1,1,1,4'd2,4'h3,1,1,4'h3);
    base_val = 32'hDEAD; cond_ok = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", got(), z);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R6 table of directed vectors
    foreach (TBL[n]) begin
      apply(TBL[n].insn, TBL[n].base, TBL[n].idx, TBL[n].pc, TBL[n].cond);
      check("R2/R3/R4/R6 table", got(),
            '{TBL[n].ea, TBL[n].ew, TBL[n].een, TBL[n].ek, 1'b0, 1'b0, 1'b0});
    end

    // R9 one cycle latency: output still holds previous vector before the edge
    @(negedge clk);
    insn = mk(1,1,1,0,1,4'd2,4'h0,0,1,4'h1); base_val = 32'h500; cond_ok = 1'b1;
    #0.5;
    total++;
    if (acc_addr !== 32'h50) begin
      bad++;
      $display("FAIL R9 latency act=%h exp=%h", acc_addr, 32'h50);
    end
    @(posedge clk);
    #1;
    check("R9 after edge", got(), model(insn, base_val, idx_val, pc_val, 1'b1));

    // sweep of P W U S H L and offset form: R3 R4 R5 R7 R8
    for (int v = 0; v < 128; v++) begin
      logic [31:0] iw;
      logic [6:0] b7;
      b7 = v[6:0];
      if (b7[0])
        iw = mk(b7[6], b7[4], 1'b1, b7[5], b7[1], 4'd6, 4'h3, b7[3], b7[2], 4'hC);
      else
        iw = mk(b7[6], b7[4], 1'b0, b7[5], b7[1], 4'd6, 4'h0, b7[3], b7[2], 4'd7);
      run("sweep R3 R4 R5 R7 R8", iw, 32'h8000_0010 + v, 32'h123, 32'h40,
          (v % 3) != 0);
    end

    // R1 outsiders
    run("R1 S=H=0", mk(1,1,1,1,1,4'd2,4'h1,0,0,4'h1), 32'h10, 0, 0, 1'b1);
    run("R1 wrong top bits", mk(1,1,1,1,1,4'd2,4'h1,0,1,4'h1) | 32'h0200_0000,
        32'h10, 0, 0, 1'b1);
    run("R1 bit7 clear", mk(1,1,1,1,1,4'd2,4'h1,0,1,4'h1) & ~32'h80,
        32'h10, 0, 0, 1'b1);
    // R7 signed store pattern is unallocated
    run("R7 unalloc", mk(0,1,1,0,0,4'd2,4'h0,1,1,4'h4), 32'h10, 0, 0, 1'b1);
    // R5 cond fail blocks pre-indexed writeback
    run("R5 cond off", mk(1,1,1,1,1,4'd2,4'h0,0,1,4'h4), 32'h10, 0, 0, 1'b0);
    // R8 undefined operand choices
    run("R8 idx 15", mk(1,1,0,0,1,4'd2,4'h0,0,1,4'd15), 32'h10, 5, 0, 1'b1);
    run("R8 base 15 wb", mk(1,1,1,1,1,4'd15,4'h0,0,1,4'h4), 32'h10, 0, 32'h80, 1'b1);
    run("R8 same reg wb", mk(0,1,0,0,1,4'd5,4'h0,0,1,4'd5), 32'h10, 2, 0, 1'b1);
    run("R8 same nibble imm ok", mk(0,1,1,0,1,4'd5,4'h0,0,1,4'd5), 32'h10, 2, 0, 1'b1);
    run("R8 sbz nibble", mk(1,1,0,0,1,4'd2,4'h4,0,1,4'd3), 32'h10, 2, 0, 1'b1);
    // R6 base 15 plain offset, register form
    run("R6 pc base", mk(1,0,0,0,1,4'd15,4'h0,1,1,4'd3), 32'h0, 32'h4, 32'h200, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule